// File: doc/BRIEF.md
# Tracking Angle Output Register

This block sits between a free-running angle counter and a shared host data bus. Each time the counter side pulses its update strobe, the block raises a busy pulse of fixed length that covers the counter's change. When the pulse ends, it captures the new count into a held output word, unless the host is holding the word frozen. The host reads the held word as two bytes. Each byte has its own active-low output enable and floats when that enable is high.

Two mode inputs pick the resolution. A third input chooses resolver or linear-sensor operation. The captured word keeps only the selected number of most-significant count bits and clears the rest. In linear-sensor mode the word is shifted right by two places, so the third bit from the top of the word carries the most significant bit. A zero-index flag is high whenever the held word is all zeros.

Top module: `angle_latch_port`

## Requirements
- R1: After reset, busy is 0, the held word is 0x0000 and zero_idx is 1.
- R2: An update strobe seen while busy is low raises busy on the next clock edge. Busy stays high for exactly BUSY_CYC cycles (125 by default, 0.5 µs at 250 MHz). A strobe that arrives while busy is high does not lengthen or restart the pulse.
- R3: The held word changes only at the clock edge where busy falls. While busy is high, the bus still shows the previous word.
- R4: If hold_n is low at the edge where busy ends, the held word is kept. Raising hold_n afterwards loads nothing until the next update pulse ends.
- R5: In resolver mode (lvdt_mode=0), the code {res_b,res_a} selects the resolution: 00 gives 10 bits, 01 gives 12, 10 gives 14 and 11 gives 16. The top N count bits land in word[15:16-N]. All lower word bits are 0.
- R6: In linear-sensor mode (lvdt_mode=1), the same codes give 8, 10, 12 and 14 bits. word[15:14] are 0. The top N count bits land in word[13:14-N]. All lower word bits are 0.
- R7: With msb_oe_n low, dbus_hi drives word[15:8]; with it high, dbus_hi is high-impedance. lsb_oe_n and dbus_lo behave the same way for word[7:0].
- R8: zero_idx is 1 exactly when the held word (after masking) is 0x0000.
- R9: Changing the mode or resolution inputs while no load occurs leaves the held word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| angle_in | input | 16 | Count from the angle counter |
| upd_stb | input | 1 | One-cycle pulse when the counter is about to change |
| hold_n | input | 1 | Low keeps the held word frozen |
| msb_oe_n | input | 1 | Active-low enable for the upper byte |
| lsb_oe_n | input | 1 | Active-low enable for the lower byte |
| res_b | input | 1 | Resolution code, upper bit |
| res_a | input | 1 | Resolution code, lower bit |
| lvdt_mode | input | 1 | 1 selects linear-sensor placement and resolutions |
| busy | output | 1 | Converter-busy pulse |
| zero_idx | output | 1 | High when the held word is zero |
| dbus_hi | output | 8 | Upper byte, tri-state |
| dbus_lo | output | 8 | Lower byte, tri-state |

## Verification
A busy counter stuck at the wrong value shows at the port as a pulse of the wrong length, seen at the falling edge of that same pulse. A wrong load condition shows on the bus as a word that changes during busy, or under hold, or without any strobe. That error is visible on the first read after the faulty edge. A wrong mask or shift gives the wrong byte values on the next read, and zero_idx then disagrees on patterns whose only set bits lie below the resolution.

// File: rtl/angle_latch_port.sv
module angle_latch_port #(
  parameter int BUSY_CYC = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [15:0] angle_in,
  input  logic       upd_stb,
  input  logic       hold_n,
  input  logic       msb_oe_n,
  input  logic       lsb_oe_n,
  input  logic       res_b,
  input  logic       res_a,
  input  logic       lvdt_mode,
  output logic       busy,
  output logic       zero_idx,
  output logic [7:0] dbus_hi,
  output logic [7:0] dbus_lo
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] bcnt;
  logic [15:0]   word_q;
  logic [4:0]    n_bits;
  logic [15:0]   keep;
  logic [15:0]   word_d;
  logic          load;

  assign n_bits = {2'b00, res_b, res_a, 1'b0} + (lvdt_mode ? 5'd8 : 5'd10);
  assign keep   = ~(16'hFFFF >> n_bits);
  assign word_d = lvdt_mode ? ((angle_in & keep) >> 2) : (angle_in & keep);
  assign load   = (bcnt == CW'(1)) && hold_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bcnt <= '0;
    else if (bcnt != '0)
      bcnt <= bcnt - CW'(1);
    else if (upd_stb)
      bcnt <= CW'(BUSY_CYC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      word_q <= '0;
    else if (load)
      word_q <= word_d;
  end

  assign busy     = (bcnt != '0);
  assign zero_idx = (word_q == 16'h0000);
  assign dbus_hi  = msb_oe_n ? 8'bzzzz_zzzz : word_q[15:8];
  assign dbus_lo  = lsb_oe_n ? 8'bzzzz_zzzz : word_q[7:0];
endmodule

// File: rtl/angle_latch_port_chk.sv
module angle_latch_port_chk #(
  parameter int BUSY_CYC = 125
) (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_stb,
  input logic        hold_n,
  input logic        lvdt_mode,
  input logic        busy,
  input logic        zero_idx,
  input logic [15:0] word_q
);
  localparam int RW = $clog2(BUSY_CYC + 1) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run <= '0;
    else if (busy)   run <= run + RW'(1);
    else             run <= '0;
  end

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run == RW'(BUSY_CYC));

  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_stb && !busy) |=> busy);

  p_word_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(word_q));

  p_hold_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(hold_n)) |-> $stable(word_q));

  p_lvdt_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(hold_n) && $past(lvdt_mode)) |-> word_q[15:14] == 2'b00);

  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(word_q) |-> $stable(zero_idx));
endmodule

bind angle_latch_port angle_latch_port_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_stb(upd_stb), .hold_n(hold_n),
  .lvdt_mode(lvdt_mode), .busy(busy), .zero_idx(zero_idx), .word_q(word_q)
);

// File: tb/sim_angle_latch_port.sv
`timescale 1ns/1ps
module sim_angle_latch_port;
  localparam int BC = 125;

  logic clk = 0, rst_n = 0;
  logic [15:0] angle_in = 0;
  logic upd_stb = 0, hold_n = 1, msb_oe_n = 1, lsb_oe_n = 1;
  logic res_b = 1, res_a = 1, lvdt_mode = 0;
  logic busy, zero_idx;
  wire [7:0] dbus_hi, dbus_lo;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (dbus_hi[i]);
    pullup (dbus_lo[i]);
  end

  angle_latch_port #(.BUSY_CYC(BC)) u0 (
    .clk(clk), .rst_n(rst_n), .angle_in(angle_in), .upd_stb(upd_stb),
    .hold_n(hold_n), .msb_oe_n(msb_oe_n), .lsb_oe_n(lsb_oe_n),
    .res_b(res_b), .res_a(res_a), .lvdt_mode(lvdt_mode),
    .busy(busy), .zero_idx(zero_idx), .dbus_hi(dbus_hi), .dbus_lo(dbus_lo));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expw(input logic [15:0] c, input logic [1:0] code, input logic lv);
    int n;
    logic [15:0] top;
    n = (lv ? 8 : 10) + 2 * code;
    top = c & (16'hFFFF << (16 - n));
    return lv ? (top >> 2) : top;
  endfunction

  task automatic rd(output logic [15:0] w);
    @(negedge clk);
    msb_oe_n = 0; lsb_oe_n = 0;
    #1 w = {dbus_hi, dbus_lo};
    msb_oe_n = 1; lsb_oe_n = 1;
  endtask

  task automatic upd(input logic [15:0] v, output int len);
    @(negedge clk);
    angle_in = v; upd_stb = 1;
    @(negedge clk);
    upd_stb = 0;
    len = 0;
    while (busy) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic set_mode(input logic lv, input logic [1:0] code);
    @(negedge clk);
    lvdt_mode = lv; {res_b, res_a} = code;
  endtask

  task automatic t_reset;
    logic [15:0] w;
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 zero_idx", {15'd0, zero_idx}, 16'd1);
    rd(w);
    chk("R1 word", w, 16'h0000);
  endtask

  task automatic t_busy;
    int len;
    logic [15:0] w;
    set_mode(0, 2'b11);
    upd(16'h1234, len);
    chk("R2 pulse length", 16'(len), 16'(BC));
    rd(w);
    chk("R3 loaded word", w, 16'h1234);
    @(negedge clk);
    angle_in = 16'hBEEF; upd_stb = 1;
    @(negedge clk);
    upd_stb = 0;
    msb_oe_n = 0; lsb_oe_n = 0;
    #1 chk("R3 old word during busy", {dbus_hi, dbus_lo}, 16'h1234);
    msb_oe_n = 1; lsb_oe_n = 1;
    len = 1;
    repeat (10) begin @(negedge clk); len++; end
    upd_stb = 1;
    @(negedge clk);
    upd_stb = 0; len++;
    while (busy) begin @(negedge clk); len++; end
    chk("R2 no retrigger", 16'(len - 1), 16'(BC));
    rd(w);
    chk("R3 word after second pulse", w, 16'hBEEF);
  endtask

  task automatic t_hold;
    int len;
    logic [15:0] w;
    @(negedge clk) hold_n = 0;
    upd(16'h7777, len);
    rd(w);
    chk("R4 frozen under hold", w, 16'hBEEF);
    @(negedge clk) hold_n = 1;
    repeat (5) @(negedge clk);
    rd(w);
    chk("R4 no load on release", w, 16'hBEEF);
    upd(16'h7777, len);
    rd(w);
    chk("R4 load on next update", w, 16'h7777);
  endtask

  task automatic t_resolver;
    int len;
    logic [15:0] w;
    logic [15:0] pats[2] = '{16'hFFFF, 16'hA5C3};
    for (int c = 0; c < 4; c++)
      foreach (pats[p]) begin
        set_mode(0, 2'(c));
        upd(pats[p], len);
        rd(w);
        chk("R5 resolver mask", w, expw(pats[p], 2'(c), 1'b0));
      end
  endtask

  task automatic t_lvdt;
    int len;
    logic [15:0] w;
    logic [15:0] pats[2] = '{16'hFFFF, 16'h5A3C};
    for (int c = 0; c < 4; c++)
      foreach (pats[p]) begin
        set_mode(1, 2'(c));
        upd(pats[p], len);
        rd(w);
        chk("R6 lvdt placement", w, expw(pats[p], 2'(c), 1'b1));
      end
  endtask

  task automatic t_enables;
    int len;
    set_mode(0, 2'b11);
    upd(16'h1234, len);
    @(negedge clk);
    msb_oe_n = 0; lsb_oe_n = 1;
    #1 chk("R7 hi only", {dbus_hi, dbus_lo}, 16'h12FF);
    @(negedge clk);
    msb_oe_n = 1; lsb_oe_n = 0;
    #1 chk("R7 lo only", {dbus_hi, dbus_lo}, 16'hFF34);
    @(negedge clk);
    msb_oe_n = 1; lsb_oe_n = 1;
    #1 chk("R7 both off", {dbus_hi, dbus_lo}, 16'hFFFF);
  endtask

  task automatic t_zero;
    int len;
    set_mode(0, 2'b00);
    upd(16'h0020, len);
    @(negedge clk);
    chk("R8 masked to zero", {15'd0, zero_idx}, 16'd1);
    upd(16'h0040, len);
    @(negedge clk);
    chk("R8 nonzero", {15'd0, zero_idx}, 16'd0);
  endtask

  task automatic t_mode;
    int len;
    logic [15:0] w;
    set_mode(0, 2'b11);
    upd(16'h1235, len);
    set_mode(1, 2'b00);
    repeat (3) @(negedge clk);
    rd(w);
    chk("R9 mode change no effect", w, 16'h1235);
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_busy;
    t_hold;
    t_resolver;
    t_lvdt;
    t_enables;
    t_zero;
    t_mode;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule